// File: doc/BRIEF.md
# Prescaled Down-Counting Reload Timer

A single timer channel on a small 32-bit register bus. The peripheral clock first passes through an 8-bit prescaler that divides by the programmed value plus one. A selectable power-of-two stage then divides it again, and its output is a one-cycle tick enable that steps a 16-bit down-counter. Software fills a count buffer and copies it into the counter with a manual-update control bit. It then starts the channel, with or without automatic reload, in a write that also clears the update bit.

The live count can be read at any time from a read-only observation register. When the counter is already at zero and the next tick arrives, the block raises a one-clock interrupt pulse. It then either reloads the counter from the buffer or, in one-shot operation, stops itself. All logic runs in a single clock domain. Read data is a combinational decode of the current address.

Top module: `pdt_timer`

## Requirements
- R1: After reset every register reads zero and irq_o is low.
- R2: Offsets and the bits each register keeps:
  - 0x00 keeps the prescale field in bits 15:8.
  - 0x04 keeps the divider select in bits 19:16.
  - 0x08 keeps the control bits 22:20.
  - 0x0C keeps the count buffer in bits 15:0.
  - All other bits read zero and ignore writes.
- R3: Offset 0x10 returns the live count in bits 15:0 and ignores writes. Unmapped offsets read zero.
- R4: While control bit 21 (manual update) is 1, the counter is loaded from the count buffer on every clock and does not count, even if the start bit is 1.
- R5: With prescale value P and divider select S, the tick period is (P+1)*2^(S+1) clocks. The first tick comes one full period after the start bit is set.
- R6: While control bit 20 (start) is 1 and bit 21 is 0, the counter decrements by one on each tick.
- R7: With control bit 22 (auto-reload) set, a tick that finds the counter at zero reloads it from the count buffer and pulses irq_o high for exactly one clock.
- R8: With bit 22 clear, a tick that finds the counter at zero leaves it at zero, clears the start bit and pulses irq_o for one clock.
- R9: Clearing the start bit freezes the counter and resets the prescaler and divider. A later start again waits a full period before the first tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write enable |
| addr_i | input | 5 | Byte address of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| irq_o | output | 1 | One-clock pulse on a zero-reached tick |

## Verification
The embedded properties assume that the bus holds write data and address stable around the clock edge. They also assume that a software write to the control register may override the self-clearing of the start bit in the same cycle, so the start-clear property is qualified by the absence of such a write. The single-cycle interrupt property relies on ticks never coming on two consecutive clocks. That holds because the smallest divider ratio is two. The directed stimulus changes bus signals only on falling edges and issues one write per cycle. It checks counts at clock offsets computed from the period formula, just before and just after each expected tick.

// File: rtl/pdt_timer_pkg.sv
package pdt_timer_pkg;
  localparam logic [7:0] OFF_CFG0 = 8'h00;
  localparam logic [7:0] OFF_CFG1 = 8'h04;
  localparam logic [7:0] OFF_CTRL = 8'h08;
  localparam logic [7:0] OFF_BUF  = 8'h0C;
  localparam logic [7:0] OFF_OBS  = 8'h10;

  localparam int PSC_LSB    = 8;
  localparam int SEL_LSB    = 16;
  localparam int START_BIT  = 20;
  localparam int MANUAL_BIT = 21;
  localparam int RELOAD_BIT = 22;

  typedef struct packed {
    logic reload;
    logic manual;
    logic start;
  } ctrl_t;
endpackage

// File: rtl/pdt_tick_gen.sv
module pdt_tick_gen #(
  parameter int PSC_W = 8,
  parameter int SEL_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [PSC_W-1:0] psc_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int DIV_W = 2 ** SEL_W;

  logic [PSC_W-1:0] psc_cnt_q;
  logic [DIV_W-1:0] div_cnt_q;
  logic [DIV_W:0]   div_lim;
  logic             pre_tick;

  // divide ratio 2^(sel+1), counter wraps at ratio-1
  assign div_lim  = ({{DIV_W{1'b0}}, 1'b1} << ((SEL_W+1)'(sel_i) + 1'b1)) - 1'b1;
  assign pre_tick = run_i && (psc_cnt_q == psc_i);
  assign tick_o   = pre_tick && (div_cnt_q == div_lim[DIV_W-1:0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      psc_cnt_q <= '0;
      div_cnt_q <= '0;
    end else if (!run_i) begin
      psc_cnt_q <= '0;
      div_cnt_q <= '0;
    end else if (pre_tick) begin
      psc_cnt_q <= '0;
      div_cnt_q <= tick_o ? '0 : div_cnt_q + 1'b1;
    end else begin
      psc_cnt_q <= psc_cnt_q + 1'b1;
    end
  end

  // R9: stopped channel produces no tick the following cycle
  p_idle_no_tick_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !tick_o);
endmodule

// File: rtl/pdt_down_cnt.sv
module pdt_down_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             manual_i,
  input  logic             reload_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] buf_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             stop_o,
  output logic             irq_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             irq_q;
  logic             at_zero_tick;

  assign at_zero_tick = tick_i && !manual_i && (cnt_q == '0);
  assign stop_o       = at_zero_tick && !reload_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= at_zero_tick;
      if (manual_i)
        cnt_q <= buf_i;
      else if (tick_i) begin
        if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
        else if (reload_i) cnt_q <= buf_i;
      end
    end
  end

  assign cnt_o = cnt_q;
  assign irq_o = irq_q;

  p_manual_load_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    manual_i |=> cnt_o == $past(buf_i));
  p_decrement_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !manual_i && cnt_o != '0) |=> cnt_o == $past(cnt_o) - 1'b1);
  p_irq_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);
  p_oneshot_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !manual_i && !reload_i && cnt_o == '0) |=> cnt_o == '0);
endmodule

// File: rtl/pdt_regs.sv
module pdt_regs
  import pdt_timer_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int PSC_W  = 8,
  parameter int SEL_W  = 4,
  parameter int CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              stop_i,
  output logic [PSC_W-1:0]  psc_o,
  output logic [SEL_W-1:0]  sel_o,
  output ctrl_t             ctrl_o,
  output logic [CNT_W-1:0]  buf_o
);
  logic [PSC_W-1:0] psc_q;
  logic [SEL_W-1:0] sel_q;
  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] buf_q;
  logic             hit_cfg0, hit_cfg1, hit_ctrl, hit_buf, hit_obs;

  assign hit_cfg0 = addr_i == ADDR_W'(OFF_CFG0);
  assign hit_cfg1 = addr_i == ADDR_W'(OFF_CFG1);
  assign hit_ctrl = addr_i == ADDR_W'(OFF_CTRL);
  assign hit_buf  = addr_i == ADDR_W'(OFF_BUF);
  assign hit_obs  = addr_i == ADDR_W'(OFF_OBS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      psc_q  <= '0;
      sel_q  <= '0;
      ctrl_q <= '0;
      buf_q  <= '0;
    end else begin
      if (we_i && hit_cfg0) psc_q <= wdata_i[PSC_LSB +: PSC_W];
      if (we_i && hit_cfg1) sel_q <= wdata_i[SEL_LSB +: SEL_W];
      if (we_i && hit_buf)  buf_q <= wdata_i[CNT_W-1:0];
      if (we_i && hit_ctrl) begin
        ctrl_q.start  <= wdata_i[START_BIT];
        ctrl_q.manual <= wdata_i[MANUAL_BIT];
        ctrl_q.reload <= wdata_i[RELOAD_BIT];
      end else if (stop_i) begin
        ctrl_q.start <= 1'b0;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (hit_cfg0) rdata_o[PSC_LSB +: PSC_W] = psc_q;
    if (hit_cfg1) rdata_o[SEL_LSB +: SEL_W] = sel_q;
    if (hit_ctrl) begin
      rdata_o[START_BIT]  = ctrl_q.start;
      rdata_o[MANUAL_BIT] = ctrl_q.manual;
      rdata_o[RELOAD_BIT] = ctrl_q.reload;
    end
    if (hit_buf)  rdata_o[CNT_W-1:0] = buf_q;
    if (hit_obs)  rdata_o[CNT_W-1:0] = cnt_i;
  end

  assign psc_o  = psc_q;
  assign sel_o  = sel_q;
  assign ctrl_o = ctrl_q;
  assign buf_o  = buf_q;

  p_oneshot_stop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !(we_i && hit_ctrl)) |=> !ctrl_o.start);
  p_write_sets_start_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && hit_ctrl) |=> ctrl_o.start == $past(wdata_i[START_BIT]));
endmodule

// File: rtl/pdt_timer.sv
module pdt_timer
  import pdt_timer_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int PSC_W  = 8,
  parameter int SEL_W  = 4,
  parameter int CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              irq_o
);
  logic [PSC_W-1:0] psc;
  logic [SEL_W-1:0] sel;
  ctrl_t            ctrl;
  logic [CNT_W-1:0] cnt_buf, cnt;
  logic             tick, stop;

  pdt_regs #(.ADDR_W(ADDR_W), .PSC_W(PSC_W), .SEL_W(SEL_W), .CNT_W(CNT_W)) u_regs (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i, .rdata_o,
    .cnt_i(cnt), .stop_i(stop), .psc_o(psc), .sel_o(sel), .ctrl_o(ctrl), .buf_o(cnt_buf)
  );

  pdt_tick_gen #(.PSC_W(PSC_W), .SEL_W(SEL_W)) u_tick (
    .clk_i, .rst_ni, .run_i(ctrl.start), .psc_i(psc), .sel_i(sel), .tick_o(tick)
  );

  pdt_down_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .manual_i(ctrl.manual), .reload_i(ctrl.reload), .tick_i(tick),
    .buf_i(cnt_buf), .cnt_o(cnt), .stop_o(stop), .irq_o(irq_o)
  );

  // R5: a tick needs a started channel
  p_tick_needs_start_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick |-> ctrl.start);
endmodule

// File: tb/sim_pdt_timer.sv
module sim_pdt_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  localparam logic [31:0] C_START  = 32'h0010_0000;
  localparam logic [31:0] C_MANUAL = 32'h0020_0000;
  localparam logic [31:0] C_RELOAD = 32'h0040_0000;

  always #2 clk = ~clk;

  pdt_timer u0 (.clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr),
                .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic count_irq(int n, output int hits);
    hits = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (irq) hits++;
    end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int a = 0; a <= 16; a += 4) begin
      rd(5'(a), d); check("R1 reset read", d, 32'h0);
    end
    check("R1 irq low", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_masking();
    logic [31:0] d;
    wr(5'h00, 32'hFFFF_FFFF); rd(5'h00, d); check("R2 cfg0 mask", d, 32'h0000_FF00);
    wr(5'h04, 32'hFFFF_FFFF); rd(5'h04, d); check("R2 cfg1 mask", d, 32'h000F_0000);
    wr(5'h0C, 32'hFFFF_1234); rd(5'h0C, d); check("R2 buf mask", d, 32'h0000_1234);
    wr(5'h08, 32'hFF8F_FFFF); rd(5'h08, d); check("R2 ctrl mask", d, 32'h0);
    wr(5'h10, 32'hFFFF_FFFF); rd(5'h10, d); check("R3 obs read-only", d, 32'h0);
    rd(5'h14, d); check("R3 unmapped", d, 32'h0);
    wr(5'h00, 32'h0); wr(5'h04, 32'h0);
  endtask

  task automatic t_manual();
    logic [31:0] d;
    wr(5'h0C, 32'd7);
    wr(5'h08, C_START | C_MANUAL);
    wait_cyc(10);
    rd(5'h10, d); check("R4 manual holds", d, 32'd7);
    wr(5'h0C, 32'd9); wait_cyc(1);
    rd(5'h10, d); check("R4 manual tracks buf", d, 32'd9);
    wr(5'h08, 32'h0);
  endtask

  task automatic t_reload();
    logic [31:0] d;
    int hits;
    wr(5'h0C, 32'd5);
    wr(5'h08, C_MANUAL);
    wr(5'h08, C_START | C_RELOAD);
    wait_cyc(2);  rd(5'h10, d); check("R6 first step", d, 32'd4);
    wait_cyc(6);  rd(5'h10, d); check("R6 three steps", d, 32'd1);
    wait_cyc(4);  rd(5'h10, d); check("R7 reload value", d, 32'd5);
    wr(5'h08, 32'h0);
    wr(5'h0C, 32'd1);
    wr(5'h08, C_MANUAL);
    wr(5'h08, C_START | C_RELOAD);
    count_irq(20, hits);
    check("R7 single-cycle irq count", 32'(hits), 32'd5);
    wr(5'h08, 32'h0);
  endtask

  task automatic t_oneshot();
    logic [31:0] d;
    int hits;
    wr(5'h0C, 32'd2);
    wr(5'h08, C_MANUAL);
    wr(5'h08, C_START);
    count_irq(10, hits);
    check("R8 one irq", 32'(hits), 32'd1);
    rd(5'h08, d); check("R8 start cleared", d, 32'h0);
    rd(5'h10, d); check("R8 stays zero", d, 32'h0);
  endtask

  task automatic t_prescale();
    logic [31:0] d;
    wr(5'h00, 32'h0000_0200);
    wr(5'h04, 32'h0001_0000);
    wr(5'h0C, 32'd100);
    wr(5'h08, C_MANUAL);
    wr(5'h08, C_START | C_RELOAD);
    wait_cyc(11); rd(5'h10, d); check("R5 before first tick", d, 32'd100);
    wait_cyc(1);  rd(5'h10, d); check("R5 first tick", d, 32'd99);
    wait_cyc(24); rd(5'h10, d); check("R5 third tick", d, 32'd97);
    wr(5'h08, C_RELOAD);
    wait_cyc(30); rd(5'h10, d); check("R9 frozen", d, 32'd97);
    wr(5'h08, C_START | C_RELOAD);
    wait_cyc(11); rd(5'h10, d); check("R9 restart full period", d, 32'd97);
    wait_cyc(1);  rd(5'h10, d); check("R9 restart tick", d, 32'd96);
    wr(5'h08, 32'h0);
  endtask

  initial begin
    #1 t_reset();
    wait_cyc(2);
    rst_n = 1'b1;
    t_reset();
    t_masking();
    t_manual();
    t_reload();
    t_oneshot();
    t_prescale();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule